// File: doc/BRIEF.md
# SPI Flash Serial Front End with Pause and Status Write Gating

This block is the serial front end of a flash-style SPI slave. It brings the serial clock, data input, chip select, pause and write-protect pins into a fast system clock domain through two-flop synchronizers. It detects serial clock edges in that domain and shifts in 8-bit instructions in SPI mode 0. It drives the serial data output together with a separate output-enable, which the pad ring turns into a tri-state buffer. The block keeps an 8-bit status register that a read-status instruction streams out and a write-status instruction updates.

A pause pin freezes a transfer in progress without losing its place. Pause entry and exit only take effect while the serial clock is low, so a change that arrives during a high phase waits for the next low phase. While paused, the output-enable is off and clock and data activity is ignored. Deselecting the device clears the whole serial state, including a pause.

A write to the status register is gated by the write-protect pin together with a lock bit held in bit 7 of the status register. The serial interface has no back-pressure: the host owns the clock, and each clock phase must last at least three system clocks so that the synchronizers and the edge detector see every edge. The block has no valid/ready interface because nothing flows between it and the rest of the chip except the status value.

Top module: `spi_flash_front`

## Requirements
- R1: After reset the output-enable is low and the status register holds its reset value 0x00.
- R2: Serial input is sampled on rising serial clock edges, most significant bit first, and the first 8 bits form the instruction. An instruction other than 0x01 or 0x05 is ignored: the output-enable stays low for the whole transfer and the status does not change.
- R3: With chip select low, a pause begins when the pause pin is low while the serial clock is low. If the pin falls while the clock is high, the pause begins only once the clock goes low.
- R4: A pause ends when the pause pin is high while the serial clock is low. If the pin rises while the clock is high, the pause ends only once the clock goes low, and that falling edge is not counted.
- R5: While paused the output-enable is low, serial clock edges and serial input are ignored, and the bit position is kept, so the transfer resumes where it stopped.
- R6: Chip select high clears the bit count, the instruction, any pause and the output stage. A write that is partly shifted in when this happens is discarded.
- R7: Instruction 0x05 streams the status register out MSB first, with the output updated on falling serial clock edges. The first bit (bit 7) appears after the falling edge that ends the eighth instruction bit. The status repeats every 8 bits until chip select rises. The output-enable is high from that first falling edge on.
- R8: Instruction 0x01 followed by one data byte updates the status only when chip select rises after exactly 16 bits. Only bit 7 (lock) and bits 3:2 (protection field), mask 0x8C, are writable. The other bits keep their reset value.
- R9: A status write is rejected when the write-protect pin is low and status bit 7 is 1. It is accepted when the write-protect pin is low and bit 7 is 0, and whenever the write-protect pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host (mode 0, idles low) |
| mosi_i | input | 1 | Serial data from the host |
| cs_n_i | input | 1 | Active-low chip select |
| pause_n_i | input | 1 | Active-low pause request |
| wprot_n_i | input | 1 | Active-low write-protect pin |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output-enable for the serial data pad |
| status_o | output | 8 | Current status register value |

## Verification
On every cycle the assertions check four things. A pause only starts or ends after a low synchronized serial clock, except when the end is caused by deselect. The bit count stays put while paused, and deselect clears the count, the pause and the output-enable. The output-enable is only ever high while a status read is running. The status only changes right after deselect, and never while the write-protect pin is low with the lock bit set. The bench scenarios show the rest: the exact bit stream of a status read across a pause, and the effect of deferred pause entry and exit on the output-enable. They also show that clock pulses given while paused are not counted, that bit counts of 15 and 17 are discarded, that unknown instructions are ignored, and that the write mask is applied.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CMD_BITS = 2 * BYTE_W;
  localparam int unsigned LOCK_BIT = BYTE_W - 1;
  localparam logic [BYTE_W-1:0] OP_WRITE_STATUS = 8'h01;
  localparam logic [BYTE_W-1:0] OP_READ_STATUS = 8'h05;

  typedef enum logic [1:0] {
    PH_OPCODE    = 2'd0,
    PH_WR_DATA   = 2'd1,
    PH_RD_STATUS = 2'd2,
    PH_DISCARD   = 2'd3
  } phase_e;
endpackage

// File: rtl/sff_sync.sv
module sff_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sff_pause_ctrl.sv
module sff_pause_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cs_n_s,
  input  logic pause_n_s,
  output logic paused_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o
);
  logic sclk_q;
  logic paused_q;
  logic raw_rise, raw_fall, live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      if (cs_n_s)       paused_q <= 1'b0;        // deselect clears a pause
      else if (!sclk_s) paused_q <= !pause_n_s;  // only act during a low phase
    end
  end

  assign raw_rise    = sclk_s & ~sclk_q;
  assign raw_fall    = ~sclk_s & sclk_q;
  assign live        = ~paused_q & ~cs_n_s;
  assign sclk_rise_o = raw_rise & live;
  assign sclk_fall_o = raw_fall & live;
  assign paused_o    = paused_q;
endmodule

// File: rtl/sff_rx_decoder.sv
module sff_rx_decoder
  import sff_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              sclk_rise,
  output phase_e            phase_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic              commit_ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(CMD_BITS + 1);
  localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] EXACT_BITS = CNT_W'(CMD_BITS);

  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_byte;
  logic [CNT_W-1:0]  cnt;
  phase_e            phase;
  logic [BYTE_W-1:0] wr_byte;

  assign next_byte = {shreg[BYTE_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      phase   <= PH_OPCODE;
      wr_byte <= '0;
    end else if (cs_n_s) begin
      shreg <= '0;
      cnt   <= '0;
      phase <= PH_OPCODE;
    end else if (sclk_rise) begin
      shreg <= next_byte;
      if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      if (phase == PH_OPCODE && cnt == OPC_LAST) begin
        unique case (next_byte)
          OP_WRITE_STATUS: phase <= PH_WR_DATA;
          OP_READ_STATUS:  phase <= PH_RD_STATUS;
          default:         phase <= PH_DISCARD;
        endcase
      end
      if (phase == PH_WR_DATA && cnt == DATA_LAST) wr_byte <= next_byte;
    end
  end

  assign phase_o     = phase;
  assign bit_cnt_o   = cnt;
  assign wr_byte_o   = wr_byte;
  assign commit_ok_o = (phase == PH_WR_DATA) && (cnt == EXACT_BITS);
endmodule

// File: rtl/sff_status_unit.sv
module sff_status_unit
  import sff_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STATUS_RST = 8'h00,
  parameter logic [BYTE_W-1:0] WR_MASK = 8'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              wprot_n_s,
  input  logic              sclk_fall,
  input  logic              paused,
  input  phase_e            phase,
  input  logic              commit_ok,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] status_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] status_q;
  logic              write_allowed;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  rd_sel;
  logic              armed;
  logic              miso_q;

  assign write_allowed = wprot_n_s | ~status_q[LOCK_BIT];
  assign rd_sel        = IDX_W'(BYTE_W - 1) - idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
    end else if (cs_n_s && commit_ok && write_allowed) begin
      status_q <= (status_q & ~WR_MASK) | (wr_byte & WR_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      idx    <= '0;
      miso_q <= 1'b0;
    end else if (cs_n_s) begin
      armed  <= 1'b0;
      idx    <= '0;
      miso_q <= 1'b0;
    end else if (sclk_fall && phase == PH_RD_STATUS) begin
      armed  <= 1'b1;
      miso_q <= status_q[rd_sel];
      idx    <= idx + IDX_W'(1);
    end
  end

  assign status_o  = status_q;
  assign miso_o    = miso_q;
  assign miso_oe_o = armed & ~paused & ~cs_n_s;
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
  import sff_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STATUS_RST = 8'h00,
  parameter logic [BYTE_W-1:0] WR_MASK = 8'h8C,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              cs_n_i,
  input  logic              pause_n_i,
  input  logic              wprot_n_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [BYTE_W-1:0] status_o
);
  localparam int unsigned CNT_W = $clog2(CMD_BITS + 2);
  localparam int unsigned PIN_W = 5;
  localparam logic [PIN_W-1:0] PIN_RST = 5'b00111;

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic sclk_s, mosi_s, cs_n_s, pause_n_s, wprot_n_s;
  logic paused, sclk_rise, sclk_fall;
  phase_e phase;
  logic [CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] wr_byte;
  logic commit_ok;

  assign pins_raw = {sclk_i, mosi_i, cs_n_i, pause_n_i, wprot_n_i};

  sff_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s)
  );

  assign {sclk_s, mosi_s, cs_n_s, pause_n_s, wprot_n_s} = pins_s;

  sff_pause_ctrl u_pause (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s),
    .pause_n_s(pause_n_s), .paused_o(paused),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall)
  );

  sff_rx_decoder #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .sclk_rise(sclk_rise), .phase_o(phase), .bit_cnt_o(bit_cnt),
    .wr_byte_o(wr_byte), .commit_ok_o(commit_ok)
  );

  sff_status_unit #(.STATUS_RST(STATUS_RST), .WR_MASK(WR_MASK)) u_stat (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .wprot_n_s(wprot_n_s),
    .sclk_fall(sclk_fall), .paused(paused), .phase(phase),
    .commit_ok(commit_ok), .wr_byte(wr_byte), .status_o(status_o),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o)
  );
endmodule

// File: rtl/sff_checker.sv
module sff_checker
  import sff_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_s,
  input logic              cs_n_s,
  input logic              wprot_n_s,
  input logic              paused,
  input logic [CNT_W-1:0]  bit_cnt,
  input phase_e            phase,
  input logic [BYTE_W-1:0] status_o,
  input logic              miso_oe_o
);
  // R3: a pause only starts after a low serial clock
  a_r3_entry_on_low_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> !$past(sclk_s));

  // R4: a pause only ends after a low serial clock, or through deselect
  a_r4_exit_on_low_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> (!$past(sclk_s) || $past(cs_n_s)));

  // R5: bit position frozen while paused
  a_r5_position_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && $past(paused)) |-> $stable(bit_cnt));

  // R6: deselect clears the serial state
  a_r6_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (bit_cnt == '0 && !paused && !miso_oe_o));

  // R7: the output is only enabled during a status read
  a_r7_oe_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe_o |-> (phase == PH_RD_STATUS));

  // R8: status only changes right after deselect
  a_r8_commit_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o) |-> $past(cs_n_s));

  // R9: lock bit with write-protect low blocks any change
  a_r9_lock_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o) |-> ($past(wprot_n_s) || !$past(status_o[LOCK_BIT])));
endmodule

bind spi_flash_front sff_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s),
  .wprot_n_s(wprot_n_s), .paused(paused), .bit_cnt(bit_cnt), .phase(phase),
  .status_o(status_o), .miso_oe_o(miso_oe_o)
);

// File: tb/spi_flash_front_test.sv
module spi_flash_front_test;
  localparam int HP = 6;  // system clocks per serial clock phase

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, pause_n = 1'b1, wprot_n = 1'b1;
  logic miso, miso_oe;
  logic [7:0] status;

  int ncheck = 0;
  int nerr = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_status = 8'h00;

  always #2.5 clk = ~clk;

  spi_flash_front uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .cs_n_i(cs_n),
    .pause_n_i(pause_n), .wprot_n_i(wprot_n), .miso_o(miso),
    .miso_oe_o(miso_oe), .status_o(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ncheck++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model of the status register, compared on every clock
  always @(negedge clk) begin
    if (cmp_en) begin
      ncheck++;
      if (status !== exp_status) begin
        nerr++;
        $display("FAIL R8/R9 status track actual=%h expected=%h", status, exp_status);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] bits, input int n,
                      output logic [23:0] rx, output logic [23:0] oev);
    rx = '0; oev = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = bits[i];
      tick(HP);
      rx  = {rx[22:0], miso};
      oev = {oev[22:0], miso_oe};
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
    end
  endtask

  function automatic void model_cmd(input logic [23:0] bits, input int n);
    if (n == 16 && bits[15:8] == 8'h01 && (wprot_n || !exp_status[7]))
      exp_status = (exp_status & ~8'h8C) | (bits[7:0] & 8'h8C);
  endfunction

  task automatic select();
    cs_n = 1'b0;
    tick(HP);
  endtask

  task automatic deselect(input logic [23:0] bits, input int n);
    tick(HP);
    cmp_en = 1'b0;
    cs_n = 1'b1;
    tick(HP);
    model_cmd(bits, n);
    cmp_en = 1'b1;
    tick(2);
  endtask

  task automatic run_cmd(input logic [23:0] bits, input int n);
    logic [23:0] rx, oev;
    select();
    xfer(bits, n, rx, oev);
    deselect(bits, n);
  endtask

  task automatic read_check(input string req);
    logic [23:0] rx, oev;
    select();
    xfer({8'h05, 16'h0000}, 24, rx, oev);
    chk({req, " read data"}, {16'h0, rx[15:0]}, {16'h0, exp_status, exp_status});
    chk({req, " oe during data"}, {16'h0, oev[15:0]}, 32'h0000FFFF);
    chk({req, " oe during opcode"}, {24'h0, oev[23:16]}, 32'h0);
    deselect(24'h0, 0);
  endtask

  initial begin
    logic [23:0] rx, oev;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    chk("R1 reset oe", {31'h0, miso_oe}, 32'h0);
    chk("R1 reset status", {24'h0, status}, 32'h00);
    cmp_en = 1'b1;

    read_check("R7");

    wprot_n = 1'b1; run_cmd({8'h01, 8'hFF}, 16);            // R8 mask
    chk("R8 masked write", {24'h0, status}, 32'h8C);
    read_check("R7");

    wprot_n = 1'b0; run_cmd({8'h01, 8'h00}, 16);            // R9 locked
    chk("R9 locked reject", {24'h0, status}, 32'h8C);

    wprot_n = 1'b1; run_cmd({8'h01, 8'h04}, 16);            // R9 pin high
    chk("R9 pin high accept", {24'h0, status}, 32'h04);

    wprot_n = 1'b0; run_cmd({8'h01, 8'h88}, 16);            // R9 unlocked
    chk("R9 unlocked accept", {24'h0, status}, 32'h88);
    run_cmd({8'h01, 8'h0C}, 16);
    chk("R9 relocked reject", {24'h0, status}, 32'h88);

    wprot_n = 1'b1;
    run_cmd({9'h0, 8'h01, 7'h06}, 15);                      // R8 short
    chk("R8 15 bits discarded", {24'h0, status}, 32'h88);
    run_cmd({7'h0, 8'h01, 8'h0C, 1'b0}, 17);                // R8 long
    chk("R8 17 bits discarded", {24'h0, status}, 32'h88);

    // R2: unknown opcode
    select();
    xfer({8'hA5, 8'h0C, 8'h00}, 24, rx, oev);
    chk("R2 unknown opcode oe", oev, 32'h0);
    deselect({8'hA5, 8'h0C, 8'h00}, 24);
    chk("R2 unknown opcode status", {24'h0, status}, 32'h88);

    // R3/R4/R5: pause inside a status read
    select();
    xfer(24'h05, 8, rx, oev);
    xfer(24'h0, 3, rx, oev);
    chk("R7 first bits", {29'h0, rx[2:0]}, {29'h0, exp_status[7:5]});
    pause_n = 1'b0; tick(HP);
    chk("R3 pause with sclk low", {31'h0, miso_oe}, 32'h0);
    for (int k = 0; k < 3; k++) begin
      mosi = ~mosi; sclk = 1'b1; tick(HP); sclk = 1'b0; tick(HP);
    end
    chk("R5 oe off in pause", {31'h0, miso_oe}, 32'h0);
    sclk = 1'b1; tick(HP);
    pause_n = 1'b1; tick(HP);
    chk("R4 exit deferred while sclk high", {31'h0, miso_oe}, 32'h0);
    sclk = 1'b0; tick(HP);
    chk("R4 exit on sclk low", {31'h0, miso_oe}, 32'h1);
    xfer(24'h0, 5, rx, oev);
    chk("R5 resume position", {27'h0, rx[4:0]}, {27'h0, exp_status[4:0]});
    sclk = 1'b1; tick(HP);
    pause_n = 1'b0; tick(HP);
    chk("R3 entry deferred while sclk high", {31'h0, miso_oe}, 32'h1);
    sclk = 1'b0; tick(HP);
    chk("R3 entry on sclk low", {31'h0, miso_oe}, 32'h0);
    pause_n = 1'b1; tick(HP);
    chk("R4 exit with sclk low", {31'h0, miso_oe}, 32'h1);
    deselect(24'h0, 0);

    // R5: pause inside a write, clock pulses ignored
    wprot_n = 1'b1;
    select();
    xfer({12'h0, 8'h01, 4'h0}, 12, rx, oev);
    pause_n = 1'b0; tick(HP);
    for (int k = 0; k < 3; k++) begin
      mosi = 1'b1; sclk = 1'b1; tick(HP); sclk = 1'b0; tick(HP);
    end
    pause_n = 1'b1; tick(HP);
    xfer(24'hC, 4, rx, oev);
    deselect({8'h01, 8'h0C}, 16);
    chk("R5 write across pause", {24'h0, status}, 32'h0C);

    // R6: deselect during a pause discards the partial write
    select();
    xfer({12'h0, 8'h01, 4'h8}, 12, rx, oev);
    pause_n = 1'b0; tick(HP);
    cmp_en = 1'b0; cs_n = 1'b1; tick(HP); cmp_en = 1'b1;
    chk("R6 partial write discarded", {24'h0, status}, 32'h0C);
    chk("R6 oe low after deselect", {31'h0, miso_oe}, 32'h0);
    pause_n = 1'b1; tick(HP);
    run_cmd({8'h01, 8'h80}, 16);
    chk("R6 fresh write after reset", {24'h0, status}, 32'h80);
    read_check("R6");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", ncheck, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      ncheck++;
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", ncheck, nerr);
      $finish;
    end
  end
endmodule